// File: doc/BRIEF.md
# Instruction Bundle Dispersal Unit

This block sits between instruction fetch and the execution pipelines. Every clock it looks at a window of two bundles of three slots each (six slots in all). Each slot carries a valid bit, a two-bit unit-type tag and an opaque payload. The block hands each valid slot to one of nine typed issue ports:

- two memory ports,
- two integer ports,
- two floating-point ports,
- three branch ports.

Slots are placed strictly in program order, and within a class the lowest free port is used first.

When a class has no port left, the first slot that misses out is held back, together with every later slot in the window, so issue never runs out of order. The block tells fetch in the same cycle which slots left (a per-slot take mask) and how many whole bundles are now finished. Fetch then moves its window on by that many bundles. A bundle that issued only in part is shown again with the slots already sent marked invalid.

The port outputs (valid, payload and slot index) are registered and appear one clock after the window that produced them.

Top module: `bundle_disperse`

## Requirements
- R1: Type tags are encoded as memory = 0, integer = 1, floating-point = 2 and branch = 3. A slot of a given type is issued only to a port of that class. Port numbers are 0-1 for memory, 2-3 for integer, 4-5 for floating-point and 6-8 for branch.
- R2: Slots are visited in program order, slot index = bundle*3 + position (0 to 5). Within a class, the n-th issued slot of that class in the window goes to the n-th port of the class.
- R3: If a valid slot finds no free port of its class, that slot and every later slot in the window are not taken in that cycle.
- R4: An invalid slot takes no port, is never marked taken, and does not stop later slots from issuing.
- R5: `slot_take_o[s]` is high in the same cycle exactly when slot s is issued from the current window.
- R6: `bundle_adv_o` counts finished bundles from the front of the window: 0, 1 or 2. A bundle is finished when every one of its valid slots is taken, so a bundle with no valid slots counts as finished. Bundle 1 counts only if bundle 0 is finished.
- R7: One clock after a slot is issued, its port shows valid high, the slot's payload and the slot's index (0 to 5).
- R8: A port that received no slot in a cycle shows valid low after the next clock edge.
- R9: While the synchronous reset is high at a clock edge, all port valid outputs are cleared.
- R10: Each issued slot occupies exactly one port, so the number of valid ports equals the number of slots taken in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| slot_vld_i | input | 6 | Valid bit per window slot |
| slot_typ_i | input | 6x2 | Unit-type tag per slot |
| slot_data_i | input | 6xW | Payload per slot |
| slot_take_o | output | 6 | Slots issued this cycle |
| bundle_adv_o | output | 2 | Whole bundles finished this cycle |
| iss_vld_o | output | 9 | Registered issue valid per port |
| iss_data_o | output | 9xW | Registered payload per port |
| iss_idx_o | output | 9x3 | Registered slot index per port |

## Verification
The hardest case to reach is a stall that splits the window. In that case bundle 0 finishes and bundle 1 stalls partway, or an invalid slot sits between two competing slots of the same class. The window is then shown again with the sent slots cleared. The stimulus builds these cases directly:

- patterns that use up one class inside bundle 1,
- sparse valid masks,
- a follow-up window that re-presents a stalled pair with the issued slots marked invalid.

In each case the take mask, the bundle count and the port mapping are checked against each other.

// File: rtl/disp_pkg.sv
package disp_pkg;
  typedef enum logic [1:0] {
    UT_MEM = 2'd0,
    UT_INT = 2'd1,
    UT_FP  = 2'd2,
    UT_BR  = 2'd3
  } utype_e;

  localparam int NCLS = 4;
endpackage

// File: rtl/disp_alloc.sv
module disp_alloc #(
  parameter int SLOTS = 6,
  parameter int N_MEM = 2,
  parameter int N_INT = 2,
  parameter int N_FP  = 2,
  parameter int N_BR  = 3,
  localparam int PORTS = N_MEM + N_INT + N_FP + N_BR,
  localparam int IDXW  = $clog2(SLOTS)
) (
  input  logic [SLOTS-1:0]           slot_vld_i,
  input  logic [SLOTS-1:0][1:0]      slot_typ_i,
  output logic [SLOTS-1:0]           take_o,
  output logic [PORTS-1:0]           port_vld_o,
  output logic [PORTS-1:0][IDXW-1:0] port_idx_o
);
  import disp_pkg::*;

  localparam int CAP  [NCLS] = '{N_MEM, N_INT, N_FP, N_BR};
  localparam int BASE [NCLS] = '{0, N_MEM, N_MEM + N_INT, N_MEM + N_INT + N_FP};

  // In-order walk: each class hands out its ports from the lowest up;
  // the first miss freezes the rest of the window.
  always_comb begin
    int   used [NCLS];
    logic blk;
    int   c;
    int   p;
    take_o     = '0;
    port_vld_o = '0;
    port_idx_o = '0;
    blk        = 1'b0;
    c          = 0;
    p          = 0;
    for (int k = 0; k < NCLS; k++) used[k] = 0;
    for (int s = 0; s < SLOTS; s++) begin
      if (slot_vld_i[s] && !blk) begin
        c = int'(slot_typ_i[s]);
        if (used[c] < CAP[c]) begin
          p              = BASE[c] + used[c];
          take_o[s]      = 1'b1;
          port_vld_o[p]  = 1'b1;
          port_idx_o[p]  = IDXW'(s);
          used[c]        = used[c] + 1;
        end else begin
          blk = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/disp_consume.sv
module disp_consume #(
  parameter int SPB     = 3,
  parameter int BUNDLES = 2,
  localparam int SLOTS  = SPB * BUNDLES,
  localparam int CW     = $clog2(BUNDLES + 1)
) (
  input  logic [SLOTS-1:0] vld_i,
  input  logic [SLOTS-1:0] take_i,
  output logic [CW-1:0]    adv_o
);
  logic [BUNDLES-1:0] done;
  logic [BUNDLES-1:0] pref;

  for (genvar b = 0; b < BUNDLES; b++) begin : g_bnd
    assign done[b] = &(take_i[b*SPB +: SPB] | ~vld_i[b*SPB +: SPB]);
    if (b == 0) begin : g_first
      assign pref[b] = done[b];
    end else begin : g_rest
      assign pref[b] = pref[b-1] & done[b];
    end
  end

  always_comb begin
    adv_o = '0;
    for (int b = 0; b < BUNDLES; b++) begin
      if (pref[b]) adv_o = CW'(b + 1);
    end
  end
endmodule

// File: rtl/disp_port.sv
module disp_port #(
  parameter int SLOTS = 6,
  parameter int W     = 16,
  localparam int IDXW = $clog2(SLOTS)
) (
  input  logic                    clk_i,
  input  logic                    rst_i,
  input  logic                    sel_vld_i,
  input  logic [IDXW-1:0]         sel_idx_i,
  input  logic [SLOTS-1:0][W-1:0] slot_data_i,
  output logic                    iss_vld_o,
  output logic [W-1:0]            iss_data_o,
  output logic [IDXW-1:0]         iss_idx_o
);
  logic [W-1:0] pick;

  always_comb begin
    pick = '0;
    for (int s = 0; s < SLOTS; s++) begin
      if (sel_idx_i == IDXW'(s)) pick = slot_data_i[s];
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      iss_vld_o  <= 1'b0;
      iss_data_o <= '0;
      iss_idx_o  <= '0;
    end else begin
      iss_vld_o  <= sel_vld_i;
      iss_data_o <= sel_vld_i ? pick : '0;
      iss_idx_o  <= sel_vld_i ? sel_idx_i : '0;
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk_i) $past(rst_i) |-> !iss_vld_o); // R9
endmodule

// File: rtl/bundle_disperse.sv
module bundle_disperse #(
  parameter int SPB     = 3,
  parameter int BUNDLES = 2,
  parameter int N_MEM   = 2,
  parameter int N_INT   = 2,
  parameter int N_FP    = 2,
  parameter int N_BR    = 3,
  parameter int W       = 16,
  localparam int SLOTS  = SPB * BUNDLES,
  localparam int PORTS  = N_MEM + N_INT + N_FP + N_BR,
  localparam int IDXW   = $clog2(SLOTS),
  localparam int CW     = $clog2(BUNDLES + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_i,
  input  logic [SLOTS-1:0]        slot_vld_i,
  input  logic [SLOTS-1:0][1:0]   slot_typ_i,
  input  logic [SLOTS-1:0][W-1:0] slot_data_i,
  output logic [SLOTS-1:0]        slot_take_o,
  output logic [CW-1:0]           bundle_adv_o,
  output logic [PORTS-1:0]        iss_vld_o,
  output logic [PORTS-1:0][W-1:0] iss_data_o,
  output logic [PORTS-1:0][IDXW-1:0] iss_idx_o
);
  logic [PORTS-1:0]           sel_vld;
  logic [PORTS-1:0][IDXW-1:0] sel_idx;

  disp_alloc #(
    .SLOTS(SLOTS), .N_MEM(N_MEM), .N_INT(N_INT), .N_FP(N_FP), .N_BR(N_BR)
  ) u_alloc (
    .slot_vld_i (slot_vld_i),
    .slot_typ_i (slot_typ_i),
    .take_o     (slot_take_o),
    .port_vld_o (sel_vld),
    .port_idx_o (sel_idx)
  );

  disp_consume #(.SPB(SPB), .BUNDLES(BUNDLES)) u_consume (
    .vld_i  (slot_vld_i),
    .take_i (slot_take_o),
    .adv_o  (bundle_adv_o)
  );

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    disp_port #(.SLOTS(SLOTS), .W(W)) u_port (
      .clk_i       (clk_i),
      .rst_i       (rst_i),
      .sel_vld_i   (sel_vld[p]),
      .sel_idx_i   (sel_idx[p]),
      .slot_data_i (slot_data_i),
      .iss_vld_o   (iss_vld_o[p]),
      .iss_data_o  (iss_data_o[p]),
      .iss_idx_o   (iss_idx_o[p])
    );
  end

  // Captured window state, used only to relate port outputs to their source.
  logic [SLOTS-1:0]      take_q;
  logic [SLOTS-1:0][1:0] typ_q;
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      take_q <= '0;
      typ_q  <= '0;
    end else begin
      take_q <= slot_take_o;
      typ_q  <= slot_typ_i;
    end
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_port_chk
    localparam logic [1:0] PCLS = (p < N_MEM) ? 2'd0 :
                                  (p < N_MEM + N_INT) ? 2'd1 :
                                  (p < N_MEM + N_INT + N_FP) ? 2'd2 : 2'd3;
    AST_PORT_CLASS: assert property (@(posedge clk_i) disable iff (rst_i)
      iss_vld_o[p] |-> (typ_q[iss_idx_o[p]] == PCLS)); // R1
    AST_PORT_FROM_TAKEN: assert property (@(posedge clk_i) disable iff (rst_i)
      iss_vld_o[p] |-> take_q[iss_idx_o[p]]); // R7
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot_chk
    AST_IN_ORDER: assert property (@(posedge clk_i) disable iff (rst_i)
      (slot_vld_i[s] && !slot_take_o[s]) |-> ((slot_take_o >> (s + 1)) == '0)); // R3
    AST_INVALID_NOT_TAKEN: assert property (@(posedge clk_i) disable iff (rst_i)
      !slot_vld_i[s] |-> !slot_take_o[s]); // R4
  end

  AST_ONE_PORT_PER_SLOT: assert property (@(posedge clk_i) disable iff (rst_i)
    $countones(iss_vld_o) == $countones(take_q)); // R10
  AST_FULL_ADVANCE: assert property (@(posedge clk_i) disable iff (rst_i)
    (bundle_adv_o == CW'(BUNDLES)) |-> ((slot_take_o | ~slot_vld_i) == '1)); // R6
endmodule

// File: tb/bundle_disperse_tb_top.sv
`timescale 1ns/1ps
module bundle_disperse_tb_top;
  localparam int W = 16;
  localparam int SLOTS = 6;
  localparam int PORTS = 9;
  localparam int NV = 10;
  localparam int BASE [4] = '{0, 2, 4, 6};

  logic clk_i = 1'b0;
  logic rst_i = 1'b1;
  logic [SLOTS-1:0]        slot_vld_i = '0;
  logic [SLOTS-1:0][1:0]   slot_typ_i = '0;
  logic [SLOTS-1:0][W-1:0] slot_data_i = '0;
  logic [SLOTS-1:0]        slot_take_o;
  logic [1:0]              bundle_adv_o;
  logic [PORTS-1:0]        iss_vld_o;
  logic [PORTS-1:0][W-1:0] iss_data_o;
  logic [PORTS-1:0][2:0]   iss_idx_o;

  int checks = 0;
  int fails = 0;

  always #10 clk_i = ~clk_i;

  bundle_disperse dut_i (
    .clk_i(clk_i), .rst_i(rst_i), .slot_vld_i(slot_vld_i), .slot_typ_i(slot_typ_i),
    .slot_data_i(slot_data_i), .slot_take_o(slot_take_o), .bundle_adv_o(bundle_adv_o),
    .iss_vld_o(iss_vld_o), .iss_data_o(iss_data_o), .iss_idx_o(iss_idx_o)
  );

  // {valid, types t5..t0, expected take mask, expected bundles finished}
  localparam logic [25:0] VEC [NV] = '{
    {6'b111111, {2'd2,2'd1,2'd0,2'd2,2'd1,2'd0}, 6'b111111, 2'd2},
    {6'b111111, {2'd3,2'd3,2'd3,2'd0,2'd0,2'd0}, 6'b000011, 2'd0},
    {6'b111100, {2'd3,2'd3,2'd3,2'd0,2'd0,2'd0}, 6'b111100, 2'd2},
    {6'b111111, {2'd1,2'd1,2'd3,2'd3,2'd3,2'd3}, 6'b000111, 2'd1},
    {6'b101010, {2'd0,2'd0,2'd0,2'd0,2'd0,2'd0}, 6'b001010, 2'd1},
    {6'b000000, {2'd3,2'd2,2'd1,2'd0,2'd3,2'd2}, 6'b000000, 2'd2},
    {6'b111111, {2'd3,2'd3,2'd1,2'd1,2'd2,2'd2}, 6'b111111, 2'd2},
    {6'b111111, {2'd0,2'd0,2'd0,2'd1,2'd1,2'd1}, 6'b000011, 2'd0},
    {6'b111110, {2'd3,2'd3,2'd3,2'd0,2'd0,2'd0}, 6'b111110, 2'd2},
    {6'b011111, {2'd3,2'd3,2'd3,2'd2,2'd2,2'd2}, 6'b000011, 2'd0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [5:0]  v_vld, v_take;
    logic [11:0] v_typ;
    logic [1:0]  v_bnd;
    logic [PORTS-1:0] e_vld;
    int e_idx [PORTS];
    int cnt [4];
    int c, p;

    repeat (3) @(posedge clk_i);
    #1;
    chk("R9 port valids during reset", 32'(iss_vld_o), 32'h0);
    @(negedge clk_i);
    rst_i = 1'b0;

    for (int k = 0; k < NV; k++) begin
      {v_vld, v_typ, v_take, v_bnd} = VEC[k];
      @(negedge clk_i);
      slot_vld_i = v_vld;
      slot_typ_i = v_typ;
      for (int s = 0; s < SLOTS; s++) slot_data_i[s] = W'(16'h100 * (k + 1) + s);
      #1;
      chk($sformatf("R3_R4_R5 take mask vec%0d", k), 32'(slot_take_o), 32'(v_take));
      chk($sformatf("R6 bundles finished vec%0d", k), 32'(bundle_adv_o), 32'(v_bnd));
      e_vld = '0;
      for (int q = 0; q < 4; q++) cnt[q] = 0;
      for (int q = 0; q < PORTS; q++) e_idx[q] = 0;
      for (int s = 0; s < SLOTS; s++) begin
        if (v_take[s]) begin
          c = int'(v_typ[2*s +: 2]);
          p = BASE[c] + cnt[c];
          e_vld[p] = 1'b1;
          e_idx[p] = s;
          cnt[c]++;
        end
      end
      @(posedge clk_i);
      #1;
      chk($sformatf("R1_R2 port valids vec%0d", k), 32'(iss_vld_o), 32'(e_vld));
      chk($sformatf("R10 ports used vec%0d", k), $countones(iss_vld_o), $countones(v_take));
      for (int q = 0; q < PORTS; q++) begin
        if (e_vld[q]) begin
          chk($sformatf("R7 idx vec%0d port%0d", k, q), 32'(iss_idx_o[q]), 32'(e_idx[q]));
          chk($sformatf("R7 data vec%0d port%0d", k, q), 32'(iss_data_o[q]),
              32'(16'h100 * (k + 1) + e_idx[q]));
        end
      end
    end

    // R8: an empty window after a full one leaves every port idle
    @(negedge clk_i);
    slot_vld_i = 6'b111111;
    slot_typ_i = {2'd2,2'd1,2'd0,2'd2,2'd1,2'd0};
    @(negedge clk_i);
    slot_vld_i = '0;
    @(posedge clk_i);
    #1;
    chk("R8 ports idle after empty window", 32'(iss_vld_o), 32'h0);

    // R9: reset while the window is full
    @(negedge clk_i);
    slot_vld_i = 6'b111111;
    rst_i = 1'b1;
    @(posedge clk_i);
    #1;
    chk("R9 reset clears valids with full window", 32'(iss_vld_o), 32'h0);
    @(negedge clk_i);
    rst_i = 1'b0;
    @(posedge clk_i);
    #1;
    chk("R1 ports refill after reset", 32'(iss_vld_o), 32'h03F);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule